// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a flash-style memory and decides what a host sees while an internal program or erase runs. The command decoder signals the start of an operation with a two-bit type code, at the point in its command sequence where status becomes valid. For a program that point is the rising edge of the fourth write strobe. For a chip erase it is the sixth. For a sector erase it is the last sector-erase command strobe, so the sector timeout window already counts as busy.

While the block is busy, every read returns a status byte instead of array contents. The top bit is a polling bit. For a program it is the inverse of the top bit of the byte being written. For an erase it is zero. The bit below it is a toggle that flips once for each completed read. All lower bits are zero.

When the done event arrives, reads pass array data through again. The host then sees the true value: the written bit after a program, or one after an erase, because erased cells read as one.

Top module: `eos_reporter`

## Requirements
- R1: After reset the block is idle, the toggle bit is 0, and `rd_data` equals `arr_data`.
- R2: `op_start` with `op_code` 2'b00 (program), 2'b01 (chip erase) or 2'b10 (sector erase, timeout included), sampled while idle, makes the block busy from the next cycle. The same `op_start` clears the toggle to 0.
- R3: While a program is busy, `rd_data[7]` is the inverse of `prog_data[7]` as sampled on the accepted start.
- R4: While an erase of either kind is busy, `rd_data[7]` is 0.
- R5: While busy, each completed read flips `rd_data[6]` one cycle after the read ends. A completed read is `rd_en` high for one or more cycles and then low. The first read after a start shows 0.
- R6: The toggle advances once per read strobe, whatever the strobe's length. Holding `rd_en` high for several cycles does not change `rd_data[6]`.
- R7: `op_done` while busy returns the block to idle on the next cycle. From then on `rd_data` equals `arr_data`.
- R8: While busy, `rd_data[5:0]` is zero.
- R9: `op_start` with `op_code` 2'b11 is ignored and the block stays idle.
- R10: While busy, a further `op_start` is ignored. The polling bit, the operation type and the toggle are all unchanged.
- R11: `op_done` while idle has no effect, and `rd_data` keeps following `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse: an operation enters its status-valid phase |
| op_code | input | 2 | Operation type carried with `op_start` |
| op_done | input | 1 | One-cycle pulse: the internal operation has finished |
| prog_data | input | 8 | Byte being programmed, sampled on an accepted start |
| rd_en | input | 1 | Host read strobe, high for the length of a read |
| arr_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Byte returned to the host |

## Verification
The output multiplexer is combinational, so the bench samples `rd_data` at the falling edge that follows the rising edge at which `op_start` or `op_done` was taken. The toggle register changes at the rising edge after `rd_en` falls. The bench therefore waits one falling edge after dropping the strobe before the next read, and keeps its own toggle model in step with that edge. Reads held for one and for two cycles are mixed through the sweep so that strobe length cannot change the expected toggle value.

// File: rtl/eos_pkg.sv
package eos_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_CHIP = 2'b01,
    OP_SECT = 2'b10,
    OP_NONE = 2'b11
  } op_kind_t;

  // polling bit reported during a busy phase
  function automatic logic poll_value(op_kind_t kind, logic last_top);
    return (kind == OP_PROG) ? ~last_top : 1'b0;
  endfunction

  function automatic logic code_is_valid(logic [1:0] code);
    return code != OP_NONE;
  endfunction
endpackage

// File: rtl/eos_op_tracker.sv
module eos_op_tracker
  import eos_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic [1:0]  op_code,
  input  logic        op_done,
  input  logic        top_bit,
  output logic        busy,
  output op_kind_t    kind,
  output logic        last_top,
  output logic        start_acc
);
  logic done_acc;

  assign start_acc = op_start && !busy && code_is_valid(op_code);
  assign done_acc  = op_done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      kind     <= OP_NONE;
      last_top <= 1'b0;
    end else if (start_acc) begin
      busy     <= 1'b1;
      kind     <= op_kind_t'(op_code);
      last_top <= top_bit;
    end else if (done_acc) begin
      busy     <= 1'b0;
    end
  end
endmodule

// File: rtl/eos_toggle_unit.sv
module eos_toggle_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic busy,
  input  logic clear,
  output logic tog,
  output logic rd_done
);
  logic rd_q;

  // a read is complete on the cycle its strobe falls
  assign rd_done = rd_q && !rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (clear)
        tog <= 1'b0;
      else if (busy && rd_done)
        tog <= ~tog;
    end
  end
endmodule

// File: rtl/eos_read_mux.sv
module eos_read_mux
  import eos_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          busy,
  input  op_kind_t      kind,
  input  logic          last_top,
  input  logic          tog,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic [DW-1:0] status_word;

  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = poll_value(kind, last_top);
    status_word[TOG_BIT]  = tog;
  end

  assign rd_data = busy ? status_word : arr_data;
endmodule

// File: rtl/eos_reporter.sv
module eos_reporter
  import eos_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [1:0]    op_code,
  input  logic          op_done,
  input  logic [DW-1:0] prog_data,
  input  logic          rd_en,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_BIT = DW - 1;

  logic     busy;
  op_kind_t kind;
  logic     last_top;
  logic     start_acc;
  logic     tog;
  logic     rd_done;

  eos_op_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .op_done(op_done), .top_bit(prog_data[POLL_BIT]), .busy(busy),
    .kind(kind), .last_top(last_top), .start_acc(start_acc)
  );

  eos_toggle_unit u_tog (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
    .clear(start_acc), .tog(tog), .rd_done(rd_done)
  );

  eos_read_mux #(.DW(DW)) u_mux (
    .busy(busy), .kind(kind), .last_top(last_top), .tog(tog),
    .arr_data(arr_data), .rd_data(rd_data)
  );
endmodule

// File: rtl/eos_reporter_chk.sv
module eos_reporter_chk
  import eos_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic [1:0]    op_code,
  input logic          op_done,
  input logic          rd_en,
  input logic [DW-1:0] arr_data,
  input logic [DW-1:0] rd_data,
  input logic          busy,
  input op_kind_t      kind,
  input logic          tog,
  input logic          rd_done,
  input logic          start_acc
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);
  p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind != OP_PROG) |-> !rd_data[POLL_BIT]);
  p_tog_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_done && !start_acc) |=> tog != $past(tog));
  p_tog_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !start_acc) |=> $stable(tog));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !busy);
  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_data == arr_data);
  p_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_data[TOG_BIT-1:0] == '0);
  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_start && op_code == OP_NONE) |=> !busy);
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_start && !op_done) |=> (busy && $stable(kind)));
  p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_done && !op_start) |=> !busy);
endmodule

bind eos_reporter eos_reporter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
  .op_done(op_done), .rd_en(rd_en), .arr_data(arr_data), .rd_data(rd_data),
  .busy(busy), .kind(kind), .tog(tog), .rd_done(rd_done), .start_acc(start_acc)
);

// File: tb/sim_eos_reporter.sv
`timescale 1ns/1ps
module sim_eos_reporter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_start = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic       op_done = 1'b0;
  logic [7:0] prog_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] arr_data = 8'h3C;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_tog;

  always #10 clk = ~clk;

  eos_reporter #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .op_done(op_done), .prog_data(prog_data), .rd_en(rd_en),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input int code, input logic [7:0] d, input bit t);
    logic pb;
    pb = (code == 0) ? ~d[7] : 1'b0;
    return {pb, t, 6'b000000};
  endfunction

  task automatic start_op(input int code, input logic [7:0] d);
    op_code = code[1:0];
    prog_data = d;
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic end_op();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  // read held for 'hold' cycles; sample while held, then release
  task automatic do_read(input int hold, output logic [7:0] seen);
    rd_en = 1'b1;
    for (int h = 0; h < hold; h++) @(negedge clk);
    seen = rd_data;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] seen;
    repeat (3) @(negedge clk);
    // R1: reset state passes array data
    check("R1 reset passthrough", rd_data, 8'h3C);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle passthrough", rd_data, 8'h3C);

    // R11: done while idle ignored
    end_op();
    arr_data = 8'hA5;
    #1 check("R11 done while idle", rd_data, 8'hA5);

    // R9: reserved code ignored
    start_op(3, 8'h00);
    arr_data = 8'h5A;
    #1 check("R9 reserved code", rd_data, 8'h5A);

    // sweep over codes and data
    for (int code = 0; code < 3; code++) begin
      for (int d = 0; d < 256; d += ((code == 0) ? 1 : 17)) begin
        int nreads;
        start_op(code, d[7:0]);
        exp_tog = 1'b0;
        // R2: busy from next cycle, toggle cleared
        check("R2 first status", rd_data, status_exp(code, d[7:0], 1'b0));
        nreads = 1 + (d % 3);
        for (int r = 0; r < nreads; r++) begin
          int hold;
          hold = 1 + ((d + r) % 2);
          do_read(hold, seen);
          // R3/R4 poll bit, R5/R6 toggle, R8 low bits zero
          if (code == 0) check("R3 R5 R6 R8 program status", seen, status_exp(code, d[7:0], exp_tog));
          else           check("R4 R5 R6 R8 erase status", seen, status_exp(code, d[7:0], exp_tog));
          exp_tog = ~exp_tog;
        end
        end_op();
        arr_data = d[7:0] ^ 8'h96;
        #1 check("R7 passthrough after done", rd_data, d[7:0] ^ 8'h96);
      end
    end

    // R10: start while busy ignored
    start_op(0, 8'h00);
    do_read(1, seen);
    check("R10 before second start", seen, 8'h80);
    start_op(1, 8'hFF);
    check("R10 second start ignored", rd_data, 8'hC0);
    do_read(2, seen);
    check("R10 R6 long read", seen, 8'hC0);
    check("R5 flip after read", rd_data, 8'h80);
    end_op();
    arr_data = 8'h80;
    #1 check("R7 true data bit7", rd_data, 8'h80);

    // R4 erase completes: array reads ones
    start_op(2, 8'h00);
    check("R4 sector erase busy", rd_data, 8'h00);
    end_op();
    arr_data = 8'hFF;
    #1 check("R7 erased data", rd_data, 8'hFF);

    // R1: reset mid-operation returns to passthrough
    start_op(0, 8'h7F);
    check("R3 busy before reset", rd_data, 8'h80);
    rst_n = 1'b0;
    #1 check("R1 reset clears busy", rd_data, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule